// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm Compare

This block keeps a running seconds, minutes and hours count that advances once for every accepted one-second tick. A host writes and reads the three time bytes, three alarm bytes, a control byte and a status byte through a simple synchronous write and combinational read port. The control byte selects the encoding of every time and alarm byte (packed decimal or plain binary), chooses a 12-hour or 24-hour clock, and holds a freeze bit that stops new updates while software loads a fresh time.

Each update is a timed sequence measured in reference-clock cycles. A busy flag rises as soon as a tick is accepted. The time bytes change a fixed lead time later. The flag then stays high through a settle interval. When the flag drops, the block gives a one-cycle update-ended pulse. In that same cycle it gives a one-cycle alarm pulse if every alarm byte matches the new time. An alarm byte with both top bits set matches anything.

Top module: `tod_alarm_clock`

## Requirements
- R1: Host register indices are seconds 0, seconds alarm 1, minutes 2, minutes alarm 3, hours 4, hours alarm 5, control 6 and status 7. A written byte reads back unchanged. The status byte shows the busy flag in bit 7 and zeros elsewhere. Indices 8 to 15 read as zero.
- R2: Seconds and minutes step by one per update and wrap from 59 to 0. The seconds wrap carries into minutes, and a minutes wrap carries into hours.
- R3: In 24-hour mode (control bit 1 = 1) hours wrap from 23 to 0.
- R4: In 12-hour mode (control bit 1 = 0) hours bit 7 flags PM and the hour runs 12, 1, ..., 11. PM toggles on 11 to 12, so 11 AM goes to 12 PM and 11 PM goes to 12 AM. 12 goes to 1 with PM unchanged.
- R5: With control bit 2 = 0 all time and alarm bytes are packed decimal (tens in bits 6:4, units in bits 3:0). With control bit 2 = 1 they are plain binary. Counting follows the selected encoding.
- R6: The busy flag (port and status bit 7) rises in the cycle after a tick is accepted. The time bytes change LEAD_CYC cycles after that. The flag stays high for LEAD_CYC + UPD_CYC cycles in total.
- R7: The update-ended pulse is high for exactly one cycle, in the cycle in which the busy flag has just fallen, once per update.
- R8: The alarm pulse is high for one cycle, together with the update-ended pulse, when all three alarm bytes match the new time. Otherwise it stays low.
- R9: An alarm byte whose bits 7 and 6 are both 1 matches any value of its field.
- R10: While control bit 7 is 1, ticks are ignored and no update starts. The first tick after the bit is cleared starts an update.
- R11: Ticks that arrive while an update is in progress are ignored.
- R12: After reset all time and alarm bytes are 0, the control byte is 0x02, and the busy flag and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle request to start an update |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| upd_busy | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle update-ended pulse |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
A wrong carry or encoding step shows up in the time bytes as soon as the one update that crosses the boundary completes. That is why the vector table starts each case one step before a wrap, in every mode pairing. A sequencer that counts the wrong number of cycles shows up at once in the measured busy-flag length and in the lead before the seconds byte changes. A sequencer that wrongly re-arms shows up as a second busy period after ticks that should have been ignored. An alarm comparator fault shows up only on the pulse that accompanies update-ended, so the match, the mismatch and the wildcard cases are each lined up on a single update.

// File: rtl/tod_pkg.sv
// Shared constants, state type and encoding helpers for the time-of-day block.
// Assumes every field value fits in 7 bits (at most 99).
package tod_pkg;
    localparam logic [3:0] IDX_SEC     = 4'd0;
    localparam logic [3:0] IDX_SEC_ALM = 4'd1;
    localparam logic [3:0] IDX_MIN     = 4'd2;
    localparam logic [3:0] IDX_MIN_ALM = 4'd3;
    localparam logic [3:0] IDX_HR      = 4'd4;
    localparam logic [3:0] IDX_HR_ALM  = 4'd5;
    localparam logic [3:0] IDX_CTL     = 4'd6;
    localparam logic [3:0] IDX_STAT    = 4'd7;

    localparam int CTL_HOLD = 7;
    localparam int CTL_BIN  = 2;
    localparam int CTL_H24  = 1;
    localparam logic [7:0] CTL_RESET = 8'h02;

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_LEAD, SEQ_SETTLE} seq_state_t;

    // Convert a stored field to a binary count.
    function automatic logic [6:0] field_dec(input logic [6:0] v, input logic bin);
        return bin ? v : (({4'd0, v[6:4]} * 7'd10) + {3'd0, v[3:0]});
    endfunction

    // Convert a binary count to the stored field form.
    function automatic logic [6:0] field_enc(input logic [6:0] v, input logic bin);
        logic [2:0] tens;
        logic [3:0] ones;
        tens = 3'(v / 7'd10);
        ones = 4'(v % 7'd10);
        return bin ? v : {tens, ones};
    endfunction
endpackage

// File: rtl/tod_update_seq.sv
// Update sequencer: accepts a tick when idle and not held, raises busy, strobes
// the counter advance after LEAD_CYC cycles, then settles for UPD_CYC cycles.
// Assumes LEAD_CYC >= 1 and UPD_CYC >= 1.
module tod_update_seq #(
    parameter int LEAD_CYC = 8,
    parameter int UPD_CYC  = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hold_i,
    output logic busy_o,
    output logic apply_o,
    output logic fin_o,
    output logic done_o
);
    import tod_pkg::*;

    localparam int MAXC  = (LEAD_CYC > UPD_CYC) ? LEAD_CYC : UPD_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] LEAD_LAST = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] UPD_LAST  = CNT_W'(UPD_CYC - 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;

    // Phase-end strobes used by the counter and the alarm register.
    assign apply_o = (state_q == SEQ_LEAD)   && (cnt_q == LEAD_LAST);
    assign fin_o   = (state_q == SEQ_SETTLE) && (cnt_q == UPD_LAST);
    assign busy_o  = (state_q != SEQ_IDLE);

    // Phase state, cycle counter and the registered update-ended pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (tick_i && !hold_i) begin
                        state_q <= SEQ_LEAD;
                        cnt_q   <= '0;
                    end
                end
                SEQ_LEAD: begin
                    if (apply_o) begin
                        state_q <= SEQ_SETTLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_SETTLE: begin
                    if (fin_o) begin
                        state_q <= SEQ_IDLE;
                        done_o  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    p_done_on_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_no_start_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && hold_i) |=> !busy_o);
    p_busy_ignores_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fin_o) |=> busy_o);
endmodule

// File: rtl/tod_time_counter.sv
// Seconds, minutes and hours storage with host writes and a one-step advance.
// The advance decodes the stored bytes in the current mode, counts in binary
// 24-hour form and re-encodes. A host write to a field wins over the advance.
module tod_time_counter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apply_i,
    input  logic       bin_i,
    input  logic       h24_i,
    input  logic       wr_sec_i,
    input  logic       wr_min_i,
    input  logic       wr_hr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o
);
    import tod_pkg::*;

    logic [6:0] sec_b, min_b, hr_b, h24_cur, h24_nxt, sec_nb, min_nb, h12_raw, h12;
    logic       s_wrap, m_wrap, pm_nxt;
    logic [7:0] sec_n, min_n, hr_n;

    // Next-time computation for one update step.
    always_comb begin
        sec_b   = field_dec(sec_o[6:0], bin_i);
        min_b   = field_dec(min_o[6:0], bin_i);
        hr_b    = field_dec(hr_o[6:0], bin_i);
        h24_cur = h24_i ? hr_b
                        : (((hr_b == 7'd12) ? 7'd0 : hr_b) + (hr_o[7] ? 7'd12 : 7'd0));
        s_wrap  = (sec_b >= 7'd59);
        m_wrap  = (min_b >= 7'd59);
        sec_nb  = s_wrap ? 7'd0 : sec_b + 7'd1;
        min_nb  = s_wrap ? (m_wrap ? 7'd0 : min_b + 7'd1) : min_b;
        h24_nxt = (s_wrap && m_wrap) ? ((h24_cur >= 7'd23) ? 7'd0 : h24_cur + 7'd1) : h24_cur;
        pm_nxt  = (h24_nxt >= 7'd12);
        h12_raw = pm_nxt ? h24_nxt - 7'd12 : h24_nxt;
        h12     = (h12_raw == 7'd0) ? 7'd12 : h12_raw;
        sec_n   = {1'b0, field_enc(sec_nb, bin_i)};
        min_n   = {1'b0, field_enc(min_nb, bin_i)};
        hr_n    = h24_i ? {1'b0, field_enc(h24_nxt, bin_i)} : {pm_nxt, field_enc(h12, bin_i)};
    end

    // Field registers: host write first, then update advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_o <= 8'h00;
            min_o <= 8'h00;
            hr_o  <= 8'h00;
        end else begin
            sec_o <= wr_sec_i ? wdata_i : (apply_i ? sec_n : sec_o);
            min_o <= wr_min_i ? wdata_i : (apply_i ? min_n : min_o);
            hr_o  <= wr_hr_i  ? wdata_i : (apply_i ? hr_n  : hr_o);
        end
    end

    p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_i && !wr_sec_i) |=> $stable(sec_o));
    p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_i && !wr_min_i) |=> $stable(min_o));
    p_hr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply_i && !wr_hr_i) |=> $stable(hr_o));
endmodule

// File: rtl/tod_alarm_match.sv
// Three alarm bytes with host writes and a per-field compare against the time.
// A byte with bits 7:6 both set is a wildcard. Compares raw stored bytes,
// so alarm and time must share one encoding.
module tod_alarm_match #(
    parameter int NFIELD = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NFIELD-1:0]      wr_i,
    input  logic [7:0]             wdata_i,
    input  logic [NFIELD-1:0][7:0] cur_i,
    output logic [NFIELD-1:0][7:0] alm_o,
    output logic                   match_o
);
    logic [NFIELD-1:0] hit;

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        // Alarm byte storage for one field.
        always_ff @(posedge clk) begin
            if (!rst_n)      alm_o[g] <= 8'h00;
            else if (wr_i[g]) alm_o[g] <= wdata_i;
        end
        // Field compare with wildcard.
        assign hit[g] = (alm_o[g][7:6] == 2'b11) || (alm_o[g] == cur_i[g]);
    end

    assign match_o = &hit;

    p_wild_sec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_o[0][7:6] == 2'b11 && alm_o[1] == cur_i[1] && alm_o[2] == cur_i[2]) |-> match_o);
    p_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_o[0][7:6] != 2'b11 && alm_o[0] != cur_i[0]) |-> !match_o);
endmodule

// File: rtl/tod_alarm_clock.sv
// Top level: control byte, host read multiplexer, sequencer, time counter and
// alarm compare. The alarm pulse is registered on the final settle cycle so it
// lines up with the update-ended pulse.
module tod_alarm_clock #(
    parameter int LEAD_CYC = 8,
    parameter int UPD_CYC  = 65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       host_we,
    input  logic [3:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       upd_busy,
    output logic       upd_done,
    output logic       alarm_hit
);
    import tod_pkg::*;

    logic [7:0]      ctl_q;
    logic            apply, fin, match;
    logic [7:0]      sec, min, hr;
    logic [2:0][7:0] alm;
    logic [2:0]      wr_alm;

    // Control byte register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctl_q <= CTL_RESET;
        else if (host_we && host_addr == IDX_CTL) ctl_q <= host_wdata;
    end

    tod_update_seq #(.LEAD_CYC(LEAD_CYC), .UPD_CYC(UPD_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(sec_tick), .hold_i(ctl_q[CTL_HOLD]),
        .busy_o(upd_busy), .apply_o(apply), .fin_o(fin), .done_o(upd_done)
    );

    tod_time_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .apply_i(apply),
        .bin_i(ctl_q[CTL_BIN]), .h24_i(ctl_q[CTL_H24]),
        .wr_sec_i(host_we && host_addr == IDX_SEC),
        .wr_min_i(host_we && host_addr == IDX_MIN),
        .wr_hr_i (host_we && host_addr == IDX_HR),
        .wdata_i(host_wdata), .sec_o(sec), .min_o(min), .hr_o(hr)
    );

    assign wr_alm = {host_we && host_addr == IDX_HR_ALM,
                     host_we && host_addr == IDX_MIN_ALM,
                     host_we && host_addr == IDX_SEC_ALM};

    tod_alarm_match #(.NFIELD(3)) u_alm (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_alm), .wdata_i(host_wdata),
        .cur_i({hr, min, sec}), .alm_o(alm), .match_o(match)
    );

    // Alarm pulse register, sampled on the last settle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm_hit <= 1'b0;
        else        alarm_hit <= fin && match;
    end

    // Host read multiplexer.
    always_comb begin
        unique case (host_addr)
            IDX_SEC:     host_rdata = sec;
            IDX_SEC_ALM: host_rdata = alm[0];
            IDX_MIN:     host_rdata = min;
            IDX_MIN_ALM: host_rdata = alm[1];
            IDX_HR:      host_rdata = hr;
            IDX_HR_ALM:  host_rdata = alm[2];
            IDX_CTL:     host_rdata = ctl_q;
            IDX_STAT:    host_rdata = {upd_busy, 7'd0};
            default:     host_rdata = 8'h00;
        endcase
    end

    p_alarm_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |-> upd_done);
    p_ctl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == IDX_CTL) |=> ctl_q == $past(host_wdata));
endmodule

// File: tb/tod_alarm_clock_test.sv
module tod_alarm_clock_test;
    localparam int LEAD = 8;
    localparam int UPD  = 65;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       host_we = 1'b0;
    logic [3:0] host_addr = 4'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       upd_busy, upd_done, alarm_hit;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tod_alarm_clock #(.LEAD_CYC(LEAD), .UPD_CYC(UPD)) uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .upd_busy(upd_busy), .upd_done(upd_done), .alarm_hit(alarm_hit)
    );

    // {ctl, sec, min, hr, exp_sec, exp_min, exp_hr}
    localparam logic [55:0] VEC [12] = '{
        56'h02_05_00_00_06_00_00,   // R2 plain step, decimal 24h
        56'h02_09_00_00_10_00_00,   // R5 decimal units carry
        56'h02_59_59_23_00_00_00,   // R2 R3 full wrap
        56'h02_59_12_07_00_13_07,   // R2 seconds carry into minutes
        56'h06_09_00_00_0A_00_00,   // R5 binary step
        56'h06_3B_3B_17_00_00_00,   // R3 R5 binary full wrap
        56'h00_59_59_11_00_00_92,   // R4 11 AM -> 12 PM
        56'h00_59_59_92_00_00_81,   // R4 12 PM -> 1 PM
        56'h00_59_59_91_00_00_12,   // R4 11 PM -> 12 AM
        56'h04_3B_3B_0C_00_00_01,   // R4 R5 binary 12 AM -> 1 AM
        56'h00_59_59_12_00_00_01,   // R4 12 AM -> 1 AM
        56'h02_59_59_09_00_00_10    // R3 R5 decimal hour carry
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic run_update(output bit dn, output bit al);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        dn = 0; al = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (upd_done) begin dn = 1; al = alarm_hit; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit dn, al;
        int busy_n, lead_n, extra;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        for (int a = 0; a < 6; a++) begin
            rd(4'(a), v); check("R12 reset field", v, 8'h00);
        end
        rd(4'd6, v); check("R12 reset control", v, 8'h02);
        check("R12 reset busy", {7'd0, upd_busy}, 8'h00);
        check("R12 reset pulses", {6'd0, upd_done, alarm_hit}, 8'h00);

        // R1 write/read map
        wr(4'd1, 8'h33); wr(4'd3, 8'h44); wr(4'd5, 8'h55);
        rd(4'd1, v); check("R1 sec alarm", v, 8'h33);
        rd(4'd3, v); check("R1 min alarm", v, 8'h44);
        rd(4'd5, v); check("R1 hr alarm", v, 8'h55);
        rd(4'd9, v); check("R1 unused index", v, 8'h00);
        wr(4'd7, 8'hFF); rd(4'd7, v); check("R1 status idle", v, 8'h00);

        // Vector table walk: R2 R3 R4 R5
        foreach (VEC[i]) begin
            wr(4'd6, VEC[i][55:48]);
            wr(4'd0, VEC[i][47:40]);
            wr(4'd2, VEC[i][39:32]);
            wr(4'd4, VEC[i][31:24]);
            run_update(dn, al);
            check("R7 done seen", {7'd0, dn}, 8'h01);
            rd(4'd0, v); check("R2 R5 table sec", v, VEC[i][23:16]);
            rd(4'd2, v); check("R2 table min", v, VEC[i][15:8]);
            rd(4'd4, v); check("R3 R4 table hr", v, VEC[i][7:0]);
        end

        // R6 busy timing and lead before the change
        wr(4'd6, 8'h02); wr(4'd0, 8'h20); wr(4'd1, 8'h00);
        host_addr = 4'd0;
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        busy_n = 0; lead_n = 0; dn = 0;
        if (upd_busy) begin busy_n++; if (host_rdata == 8'h20) lead_n++; end
        for (int i = 0; i < 200 && !dn; i++) begin
            @(negedge clk);
            if (upd_busy) begin busy_n++; if (host_rdata == 8'h20) lead_n++; end
            if (upd_done) dn = 1;
        end
        check("R6 busy length", 8'(busy_n), 8'(LEAD + UPD));
        check("R6 lead cycles", 8'(lead_n), 8'(LEAD));
        check("R7 done after busy", {7'd0, dn}, 8'h01);
        @(negedge clk); check("R7 done one cycle", {7'd0, upd_done}, 8'h00);

        // R8 alarm match and mismatch
        wr(4'd0, 8'h29); wr(4'd2, 8'h20); wr(4'd4, 8'h10);
        wr(4'd1, 8'h30); wr(4'd3, 8'h20); wr(4'd5, 8'h10);
        run_update(dn, al); check("R8 alarm match", {7'd0, al}, 8'h01);
        @(negedge clk); check("R8 alarm one cycle", {7'd0, alarm_hit}, 8'h00);
        wr(4'd0, 8'h29); wr(4'd3, 8'h21);
        run_update(dn, al); check("R8 alarm mismatch", {7'd0, al}, 8'h00);

        // R9 wildcards
        wr(4'd0, 8'h07); wr(4'd2, 8'h00); wr(4'd4, 8'h10);
        wr(4'd1, 8'hC0); wr(4'd3, 8'hFF); wr(4'd5, 8'h10);
        run_update(dn, al); check("R9 wildcard match", {7'd0, al}, 8'h01);
        wr(4'd5, 8'h11);
        run_update(dn, al); check("R9 hour not wild", {7'd0, al}, 8'h00);

        // R10 hold bit
        wr(4'd6, 8'h82); wr(4'd0, 8'h40);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        extra = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (upd_busy) extra++; end
        check("R10 no busy while held", 8'(extra), 8'h00);
        rd(4'd0, v); check("R10 time frozen", v, 8'h40);
        wr(4'd6, 8'h02);
        run_update(dn, al);
        rd(4'd0, v); check("R10 resumes", v, 8'h41);

        // R11 ticks during an update
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (3) @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (30) @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        repeat (60) @(negedge clk);
        extra = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (upd_busy) extra++; end
        check("R11 no rearm", 8'(extra), 8'h00);
        rd(4'd0, v); check("R11 single step", v, 8'h42);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule